// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is the programmable timer of a per-processor interrupt controller. Software sets a divide value, a timer entry and an initial count through a small register port. The timer then produces interrupt pulses, either once or every period, each tagged with the vector held in the entry. A free-running time base drives it. The block does not decrement a count. It stores the time-base value captured when the initial count was written, and it derives both the expiry moments and the readable current count from the time that has passed since that load.

Elapsed divided ticks are the raw time since the load, shifted right by the divide shift. One period is the initial count plus one divided ticks. The time base is expected to advance by at most one unit per clock.

Top module: `lic_timer`

## Requirements
- R1: After reset, the timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The initial count, the divide value and the current count all read 0, and `irq_valid` is low.
- R2: Register addresses are: 0 is the timer entry (vector in bits 7:0, mask in bit 16, periodic in bit 17); 1 is the initial count; 2 is the divide shift (bits 2:0, dividing by 2^shift); 3 is the current count. Address 3 is read-only, and a write to it changes nothing.
- R3: Writing the initial count captures the present `tbase` as the load time. Elapsed divided ticks are (`tbase` − load time) >> shift.
- R4: In one-shot mode exactly one expiry occurs, when the raw elapsed time equals (initial count + 1) << shift. No later expiry occurs until the initial count is written again.
- R5: In periodic mode an expiry occurs whenever the raw elapsed time is a nonzero whole multiple of (initial count + 1) << shift.
- R6: With an initial count of 0, no expiry is produced in either mode, and the current count reads 0.
- R7: While the mask bit is set, expiries produce no interrupt, but the schedule keeps running from the load time. A change to the mask applies from the clock edge after the write.
- R8: An expiry at the edge where `tbase` reaches the expiry time sets `irq_valid` for exactly the following cycle. `irq_vector` carries entry bits 7:0 at that time.
- R9: The current count reads the initial count minus (elapsed ticks mod period) in periodic mode. In one-shot mode it reads the initial count minus elapsed ticks until the count is used up, and 0 after that.
- R10: If an initial-count write lands on the same edge as an expiry, that expiry is still reported, and the new count starts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase | input | TW | Free-running time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CW | Combinational read data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |

## Verification
Two events can land on the same clock edge: a register write and a timer expiry. The bench provokes this on purpose. It reloads the initial count exactly on an edge where an expiry falls, and it toggles the mask on edges where an expiry falls. It then checks that the expiry judged from the state before the write is still reported, and that the count read afterwards follows the new load time. Random runs also make these collisions happen by chance, and the bench model judges every edge by the same rule: the write takes effect only after the edge.

// File: rtl/lic_timer.sv
module lic_timer #(
  parameter int TW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tbase,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          irq_valid,
  output logic [7:0]    irq_vector
);
  localparam int EW = ((TW > CW) ? TW : CW) + 1;

  logic [7:0]    vec_q;
  logic          mask_q, per_q, armed_q;
  logic [CW-1:0] init_q;
  logic [2:0]    sh_q;
  logic [TW-1:0] load_q;
  logic [CW:0]   tgt_q;

  wire [TW-1:0] raw   = tbase - load_q;
  wire [TW-1:0] ticks = raw >> sh_q;
  wire [EW-1:0] tk_e  = EW'(ticks);
  wire [EW-1:0] tg_e  = EW'(tgt_q);
  wire [CW:0]   period = {1'b0, init_q} + 1'b1;
  wire          live  = armed_q && (init_q != '0);
  wire          hit   = live && (tk_e >= tg_e);
  wire [CW-1:0] cur   = hit ? (per_q ? init_q : '0)
                      : live ? CW'(tg_e - tk_e - 1'b1) : '0;

  wire unused_ok = ^{wr_data[CW-1:18], wr_data[15:8]};

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = CW'({per_q, mask_q, 8'h00, vec_q});
      2'd1:    rd_data = init_q;
      2'd2:    rd_data = CW'(sh_q);
      default: rd_data = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      per_q      <= 1'b0;
      init_q     <= '0;
      sh_q       <= '0;
      load_q     <= '0;
      tgt_q      <= '0;
      armed_q    <= 1'b0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= hit && !mask_q;
      irq_vector <= vec_q;
      if (hit) begin
        if (per_q) tgt_q <= tgt_q + period;
        else       armed_q <= 1'b0;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            vec_q  <= wr_data[7:0];
            mask_q <= wr_data[16];
            per_q  <= wr_data[17];
          end
          2'd1: begin
            init_q  <= wr_data;
            load_q  <= tbase;
            tgt_q   <= {1'b0, wr_data} + 1'b1;
            armed_q <= 1'b1;
          end
          2'd2: sh_q <= wr_data[2:0];
          default: ;
        endcase
      end
    end
  end

  a_r7_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> !irq_valid);
  a_r6_zero_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q == '0) |=> !irq_valid);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);
  a_r4_idle_after_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !(wr_en && wr_addr == 2'd1)) |=> (!armed_q && !irq_valid));
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3) |-> (rd_data <= init_q));
endmodule

// File: tb/lic_timer_test.sv
module lic_timer_test;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tbase = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd3;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int total = 0, bad = 0, seen = 0;

  logic [7:0]  m_vec = '0;
  logic        m_mask = 1'b1, m_per = 1'b0;
  logic [31:0] m_init = '0, m_load = '0;
  logic [2:0]  m_sh = '0;

  always #(PER/2) clk = ~clk;

  lic_timer uut (.clk(clk), .rst_n(rst_n), .tbase(tbase), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_valid(irq_valid), .irq_vector(irq_vector));

  function automatic logic exp_hit(input logic [31:0] tb);
    logic [31:0] raw;
    logic [63:0] pr;
    raw = tb - m_load;
    pr  = 64'(m_init + 64'd1) << m_sh;
    if (m_init == 0 || raw == 0) return 1'b0;
    if (m_per) return (64'(raw) % pr) == 0;
    return 64'(raw) == pr;
  endfunction

  function automatic logic [31:0] exp_cur(input logic [31:0] tb);
    logic [31:0] e;
    e = (tb - m_load) >> m_sh;
    if (m_init == 0) return 0;
    if (m_per) return m_init - 32'(64'(e) % (64'(m_init) + 1));
    return (e >= m_init) ? 32'd0 : m_init - e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at tbase=%0d", req, act, exp, tbase);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d);
    logic e_irq;
    logic [7:0] e_vec;
    string tag;
    wr_en = we; wr_addr = a; wr_data = d;
    e_irq = exp_hit(tbase) && !m_mask;
    e_vec = m_vec;
    tag = (m_init == 0) ? "R6" : m_mask ? "R7" : m_per ? "R5" : "R4";
    @(posedge clk);
    if (we) begin
      case (a)
        2'd0: begin m_vec = d[7:0]; m_mask = d[16]; m_per = d[17]; end
        2'd1: begin m_init = d; m_load = tbase; end
        2'd2: m_sh = d[2:0];
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(tag, 32'(irq_valid), 32'(e_irq));
    if (e_irq) begin
      seen++;
      chk("R8", 32'(irq_vector), 32'(e_vec));
    end
    rd_addr = 2'd3; #1;
    chk("R9", rd_data, exp_cur(tbase));
    tbase = tbase + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0);
  endtask

  task automatic setup(input logic [2:0] sh, input logic [7:0] v, input logic msk,
                       input logic per, input logic [31:0] n);
    step(1'b1, 2'd1, 32'd0);
    step(1'b1, 2'd2, 32'(sh));
    step(1'b1, 2'd0, {14'd0, per, msk, 8'd0, v});
    step(1'b1, 2'd1, n);
  endtask

  initial begin
    #(PER*150000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    s0 = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_addr = 2'd0; #1; chk("R1", rd_data, 32'h0001_0000);
    rd_addr = 2'd1; #1; chk("R1", rd_data, 32'd0);
    rd_addr = 2'd2; #1; chk("R1", rd_data, 32'd0);
    rd_addr = 2'd3; #1; chk("R1", rd_data, 32'd0);
    chk("R1", 32'(irq_valid), 32'd0);
    idle(5);

    // R4: one-shot, exactly one pulse
    seen = 0;
    setup(3'd0, 8'h41, 1'b0, 1'b0, 32'd6);
    idle(30);
    chk("R4", 32'(seen), 32'd1);

    // R5: periodic, shift 0
    seen = 0;
    setup(3'd0, 8'h52, 1'b0, 1'b1, 32'd4);
    idle(50);
    chk("R5", 32'(seen), 32'd10);

    // R3: divided ticks with shift 2
    setup(3'd2, 8'h33, 1'b0, 1'b1, 32'd9);
    idle(13);
    chk("R3", rd_data, 32'd6);

    // R2: write to current count is ignored; divide register readback
    step(1'b1, 2'd3, 32'h1234);
    rd_addr = 2'd2; #1; chk("R2", rd_data, 32'd2);
    rd_addr = 2'd1; #1; chk("R2", rd_data, 32'd9);
    rd_addr = 2'd3;

    // R6: zero count in both modes
    seen = 0;
    setup(3'd0, 8'h10, 1'b0, 1'b1, 32'd0);
    idle(20);
    setup(3'd0, 8'h11, 1'b0, 1'b0, 32'd0);
    idle(20);
    chk("R6", 32'(seen), 32'd0);

    // R10: reload exactly on the expiry edge
    seen = 0;
    setup(3'd0, 8'h7a, 1'b0, 1'b0, 32'd4);
    idle(4);
    step(1'b1, 2'd1, 32'd7);
    chk("R10", 32'(seen), 32'd1);
    idle(20);
    chk("R10", 32'(seen), 32'd2);

    // R7: mask set on an expiry edge still lets that one out, then silences
    seen = 0;
    setup(3'd0, 8'h66, 1'b0, 1'b1, 32'd2);
    idle(2);
    step(1'b1, 2'd0, {14'd0, 1'b1, 1'b1, 8'd0, 8'h66});
    chk("R7", 32'(seen), 32'd1);
    idle(20);
    chk("R7", 32'(seen), 32'd1);
    step(1'b1, 2'd0, {14'd0, 1'b1, 1'b0, 8'd0, 8'h67});
    idle(10);

    // random scenarios
    for (int k = 0; k < 40; k++) begin
      logic [2:0] sh;
      logic per;
      logic [31:0] n;
      logic [7:0] v;
      sh  = 3'($urandom_range(0, 3));
      per = 1'($urandom_range(0, 1));
      n   = 32'($urandom_range(0, 30));
      v   = 8'($urandom);
      setup(sh, v, 1'($urandom_range(0, 3) == 0), per, n);
      for (int c = 0; c < 150; c++) begin
        int r;
        r = int'($urandom_range(0, 99));
        if (r < 3)
          step(1'b1, 2'd0, {14'd0, per, 1'($urandom_range(0, 1)), 8'd0, v});
        else if (r < 4)
          step(1'b1, 2'd1, 32'($urandom_range(1, 30)));
        else
          step(1'b0, 2'd0, 32'd0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule